// File: doc/BRIEF.md
# Indirect Word-Pair Address Resolver

This block follows a chain of indirect pointers until it reaches a final generalized address, meaning a segment number plus a word number. Each pointer takes up two 36-bit words, which the block reads at consecutive word numbers in one segment. The first word gives a target segment and word together with a mode code. The second word's mode says how the target word number is indexed and whether the result is itself the address of another pointer pair.

A pointer pair can also be left unresolved on purpose by giving its first word the unlinked mode. The resolver then stops and raises a trap carrying that word's segment and word fields. Supervisory software uses those fields to find the symbolic reference, installs the real pointer, and restarts the resolution.

The resolver has two interfaces:
- a memory read port that holds each request until the memory grants it;
- a start/done/trap handshake toward the requester.

Top module: `ipair_resolver`

## Requirements
- R1: For each pair at current address (s, w), the block reads word (s, w) first and then word (s, w+1), with the word number wrapping modulo 2^18. It holds the request address stable while `rd_ready` is low, and data is taken in the cycle `rd_ready` is high.
- R2: Word layout is segment in bits 35:22, word number in bits 21:4 and mode in bits 3:0. A first word with mode 0 (pointer) supplies the next address from its segment and word fields.
- R3: Second-word mode bits 1:0 select the indexing of the next word number: 0 adds nothing, 1 adds the second word's bits 21:4, 2 adds `index_val`. The sum wraps modulo 2^18 and the segment is unchanged.
- R4: If second-word mode bit 2 is set, the next address is treated as another pair and resolution repeats. Otherwise `done` pulses for one cycle with the final address on `res_seg`/`res_wrd`.
- R5: A first word with mode 3 (unlinked) ends the run with a one-cycle `trap`. In that case `trap_kind`=1 and `trap_seg`/`trap_wrd` carry that word's segment and word fields.
- R6: The run ends with `trap_kind`=2 when the first-word mode is neither 0 nor 3, or the second-word mode has bit 3 set, or its index select is 3. The trap address is the address of the offending pair.
- R7: At most MAX_DEPTH (8) pairs are resolved per run. If pair number MAX_DEPTH still requests chaining, the run ends with `trap_kind`=3 and the trap address is that pair's address. A chain that ends directly at pair MAX_DEPTH completes normally.
- R8: `busy` is high from the cycle after an accepted start until the cycle `done` or `trap` is high. `done` and `trap` are never high together, and `busy` is low while either is high. Starts seen while busy are ignored.
- R9: After reset, `busy`, `rd_req`, `done` and `trap` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin resolution when idle |
| start_seg | input | 14 | Segment of the first pair |
| start_wrd | input | 18 | Word number of the first pair |
| index_val | input | 18 | Index value added by index select 2 |
| busy | output | 1 | Resolution in progress |
| rd_req | output | 1 | Memory read request |
| rd_seg | output | 14 | Read segment |
| rd_wrd | output | 18 | Read word number |
| rd_ready | input | 1 | Read data valid this cycle |
| rd_data | input | 36 | Read data |
| done | output | 1 | One-cycle pulse on successful resolution |
| res_seg | output | 14 | Resolved segment |
| res_wrd | output | 18 | Resolved word number |
| trap | output | 1 | One-cycle pulse on abnormal end |
| trap_kind | output | 2 | 1 unlinked, 2 illegal mode, 3 depth exceeded |
| trap_seg | output | 14 | Trap segment argument |
| trap_wrd | output | 18 | Trap word argument |

## Verification
Four properties are checked on every cycle:
- the request address is held while a read stalls;
- the second read of a pair sits one word above the first;
- `done` and `trap` are exclusive and only appear once `busy` has dropped;
- the depth counter is never advanced past its limit.

The bench scenarios cover the rest: the arithmetic of each index select including the wrap, correct sequencing through multi-pair chains, the precise trap argument chosen for each fault class, the boundary between eight resolved pairs and a depth trap, and the discarding of a start issued mid-run.

// File: rtl/ipair_pkg.sv
package ipair_pkg;
    localparam int SEG_W  = 14;
    localparam int WRD_W  = 18;
    localparam int MODE_W = 4;
    localparam int DATA_W = SEG_W + WRD_W + MODE_W;

    typedef struct packed {
        logic [SEG_W-1:0] seg;
        logic [WRD_W-1:0] wrd;
    } gaddr_t;

    typedef struct packed {
        logic [SEG_W-1:0]  seg;
        logic [WRD_W-1:0]  wrd;
        logic [MODE_W-1:0] mode;
    } pword_t;

    localparam logic [MODE_W-1:0] FM_POINTER  = 4'd0;
    localparam logic [MODE_W-1:0] FM_UNLINKED = 4'd3;

    // second-word mode: [1:0] index select, [2] chain, [3] reserved
    typedef enum logic [1:0] {
        IX_NONE = 2'd0,
        IX_DISP = 2'd1,
        IX_REG  = 2'd2,
        IX_BAD  = 2'd3
    } ixsel_e;

    typedef enum logic [1:0] {
        TK_NONE    = 2'd0,
        TK_LINK    = 2'd1,
        TK_ILLEGAL = 2'd2,
        TK_LOOP    = 2'd3
    } trap_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } phase_e;

    function automatic logic [WRD_W-1:0] wrd_add(input logic [WRD_W-1:0] a,
                                                  input logic [WRD_W-1:0] b);
        return a + b;
    endfunction
endpackage

// File: rtl/ipair_decode.sv
module ipair_decode
    import ipair_pkg::*;
(
    input  pword_t              first,
    input  pword_t              second,
    input  logic [WRD_W-1:0]    index_val,
    output gaddr_t              next_addr,
    output logic                chain,
    output trap_e               fault
);
    ixsel_e           sel;
    logic [WRD_W-1:0] offset;

    always_comb begin
        sel = ixsel_e'(second.mode[1:0]);
        case (sel)
            IX_DISP: offset = second.wrd;
            IX_REG:  offset = index_val;
            default: offset = '0;
        endcase
        next_addr.seg = first.seg;
        next_addr.wrd = wrd_add(first.wrd, offset);
        chain         = second.mode[2];
        if (first.mode == FM_UNLINKED)
            fault = TK_LINK;
        else if (first.mode != FM_POINTER)
            fault = TK_ILLEGAL;
        else if (second.mode[3] || sel == IX_BAD)
            fault = TK_ILLEGAL;
        else
            fault = TK_NONE;
    end
endmodule

// File: rtl/ipair_depth.sv
module ipair_depth #(
    parameter int MAX_DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = (MAX_DEPTH > 2) ? $clog2(MAX_DEPTH) : 1;
    localparam logic [CW-1:0] LAST_V = CW'(MAX_DEPTH - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

    assign last = (cnt == LAST_V);

    // R7
    depth_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr) |-> !last);
endmodule

// File: rtl/ipair_resolver.sv
module ipair_resolver
    import ipair_pkg::*;
#(
    parameter int MAX_DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [ipair_pkg::SEG_W-1:0]  start_seg,
    input  logic [ipair_pkg::WRD_W-1:0]  start_wrd,
    input  logic [ipair_pkg::WRD_W-1:0]  index_val,
    output logic                       busy,
    output logic                       rd_req,
    output logic [ipair_pkg::SEG_W-1:0]  rd_seg,
    output logic [ipair_pkg::WRD_W-1:0]  rd_wrd,
    input  logic                       rd_ready,
    input  logic [ipair_pkg::DATA_W-1:0] rd_data,
    output logic                       done,
    output logic [ipair_pkg::SEG_W-1:0]  res_seg,
    output logic [ipair_pkg::WRD_W-1:0]  res_wrd,
    output logic                       trap,
    output logic [1:0]                 trap_kind,
    output logic [ipair_pkg::SEG_W-1:0]  trap_seg,
    output logic [ipair_pkg::WRD_W-1:0]  trap_wrd
);
    phase_e  phase;
    gaddr_t  cur;
    pword_t  first_q;
    pword_t  second_w;
    gaddr_t  res_q;
    gaddr_t  trap_at;
    trap_e   tkind_q;
    gaddr_t  next_addr;
    logic    chain;
    trap_e   fault;
    logic    at_last;
    logic    pair_in;
    logic    d_clr;
    logic    d_inc;

    assign second_w = pword_t'(rd_data);
    assign pair_in  = (phase == ST_SECOND) && rd_ready;

    ipair_decode u_decode (
        .first     (first_q),
        .second    (second_w),
        .index_val (index_val),
        .next_addr (next_addr),
        .chain     (chain),
        .fault     (fault)
    );

    assign d_clr = (phase == ST_IDLE) && start;
    assign d_inc = pair_in && (fault == TK_NONE) && chain && !at_last;

    ipair_depth #(.MAX_DEPTH(MAX_DEPTH)) u_depth (
        .clk  (clk),
        .rst  (rst),
        .clr  (d_clr),
        .inc  (d_inc),
        .last (at_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= ST_IDLE;
            cur     <= '0;
            first_q <= '0;
            res_q   <= '0;
            trap_at <= '0;
            tkind_q <= TK_NONE;
            done    <= 1'b0;
            trap    <= 1'b0;
        end else begin
            done <= 1'b0;
            trap <= 1'b0;
            case (phase)
                ST_IDLE: begin
                    if (start) begin
                        cur.seg <= start_seg;
                        cur.wrd <= start_wrd;
                        phase   <= ST_FIRST;
                    end
                end
                ST_FIRST: begin
                    if (rd_ready) begin
                        first_q <= pword_t'(rd_data);
                        phase   <= ST_SECOND;
                    end
                end
                ST_SECOND: begin
                    if (rd_ready) begin
                        if (fault != TK_NONE) begin
                            trap    <= 1'b1;
                            tkind_q <= fault;
                            if (fault == TK_LINK) begin
                                trap_at.seg <= first_q.seg;
                                trap_at.wrd <= first_q.wrd;
                            end else begin
                                trap_at <= cur;
                            end
                            phase <= ST_IDLE;
                        end else if (chain && at_last) begin
                            trap    <= 1'b1;
                            tkind_q <= TK_LOOP;
                            trap_at <= cur;
                            phase   <= ST_IDLE;
                        end else if (chain) begin
                            cur   <= next_addr;
                            phase <= ST_FIRST;
                        end else begin
                            done  <= 1'b1;
                            res_q <= next_addr;
                            phase <= ST_IDLE;
                        end
                    end
                end
                default: phase <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (phase != ST_IDLE);
    assign rd_req    = busy;
    assign rd_seg    = cur.seg;
    assign rd_wrd    = wrd_add(cur.wrd, WRD_W'(phase == ST_SECOND));
    assign res_seg   = res_q.seg;
    assign res_wrd   = res_q.wrd;
    assign trap_seg  = trap_at.seg;
    assign trap_wrd  = trap_at.wrd;
    assign trap_kind = tkind_q;

    // R1
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ready) |=> (rd_req && $stable(rd_seg) && $stable(rd_wrd)));

    // R1
    pair_step_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_FIRST && rd_ready) |=>
            (rd_req && rd_seg == $past(rd_seg) && rd_wrd == $past(rd_wrd) + WRD_W'(1)));

    // R8
    end_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && trap));

    // R8
    end_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (done || trap) |-> !busy);

    // R5
    trap_code_chk: assert property (@(posedge clk) disable iff (rst)
        trap |-> (trap_kind != 2'd0));
endmodule

// File: tb/tb_ipair_resolver.sv
`timescale 1ns/1ps
module tb_ipair_resolver;
    import ipair_pkg::*;

    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst;
    always #4 clk = ~clk;

    logic              start = 1'b0;
    logic [SEG_W-1:0]  start_seg = '0;
    logic [WRD_W-1:0]  start_wrd = '0;
    logic [WRD_W-1:0]  index_val = '0;
    logic              busy, rd_req, done, trap;
    logic [SEG_W-1:0]  rd_seg, res_seg, trap_seg;
    logic [WRD_W-1:0]  rd_wrd, res_wrd, trap_wrd;
    logic              rd_ready = 1'b0;
    logic [DATA_W-1:0] rd_data = '0;
    logic [1:0]        trap_kind;

    ipair_resolver #(.MAX_DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .start(start), .start_seg(start_seg),
        .start_wrd(start_wrd), .index_val(index_val), .busy(busy),
        .rd_req(rd_req), .rd_seg(rd_seg), .rd_wrd(rd_wrd),
        .rd_ready(rd_ready), .rd_data(rd_data), .done(done),
        .res_seg(res_seg), .res_wrd(res_wrd), .trap(trap),
        .trap_kind(trap_kind), .trap_seg(trap_seg), .trap_wrd(trap_wrd)
    );

    logic [DATA_W-1:0] mem [int unsigned];
    int unsigned exp_q[$];
    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit got_done, got_trap;
    int got_kind, got_seg, got_wrd;

    function automatic int unsigned key(input logic [SEG_W-1:0] s, input logic [WRD_W-1:0] w);
        return {s, w};
    endfunction

    function automatic logic [DATA_W-1:0] peek(input int unsigned k);
        if (mem.exists(k)) return mem[k];
        return DATA_W'(36'hF);
    endfunction

    function automatic logic [DATA_W-1:0] mkw(input int s, input int w, input int m);
        return {SEG_W'(s), WRD_W'(w), MODE_W'(m)};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory model and per-cycle read-address comparison
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (done || trap) begin
                check(busy == 1'b0, "R8", "busy while ending", busy, 0);
                check(!(done && trap), "R8", "done and trap together", {done, trap}, 0);
            end
            if (done) begin
                got_done = 1; got_seg = res_seg; got_wrd = res_wrd;
            end
            if (trap) begin
                got_trap = 1; got_kind = trap_kind; got_seg = trap_seg; got_wrd = trap_wrd;
            end
        end
        rd_ready = ((cyc % 4) != 2);
        rd_data  = peek(key(rd_seg, rd_wrd));
        if (!rst && rd_req && rd_ready) begin
            if (exp_q.size() == 0)
                check(0, "R1", "unexpected read", key(rd_seg, rd_wrd), 0);
            else begin
                int unsigned e;
                e = exp_q.pop_front();
                check(key(rd_seg, rd_wrd) == e, "R1", "read address", key(rd_seg, rd_wrd), e);
            end
        end
    end

    task automatic model(input int s0, input int w0, input int idx,
                         output int kind, output int es, output int ew);
        logic [SEG_W-1:0] cs;
        logic [WRD_W-1:0] cw, cw1, off, nw;
        pword_t a, b;
        cs = SEG_W'(s0); cw = WRD_W'(w0);
        kind = -1; es = 0; ew = 0;
        exp_q.delete();
        for (int d = 1; d <= DEPTH; d++) begin
            cw1 = cw + WRD_W'(1);
            exp_q.push_back(key(cs, cw));
            exp_q.push_back(key(cs, cw1));
            a = pword_t'(peek(key(cs, cw)));
            b = pword_t'(peek(key(cs, cw1)));
            if (a.mode == 4'd3) begin kind = 1; es = a.seg; ew = a.wrd; return; end
            if (a.mode != 4'd0 || b.mode[3] || b.mode[1:0] == 2'd3) begin
                kind = 2; es = cs; ew = cw; return;
            end
            off = (b.mode[1:0] == 2'd1) ? b.wrd : (b.mode[1:0] == 2'd2) ? WRD_W'(idx) : '0;
            nw  = a.wrd + off;
            if (!b.mode[2]) begin kind = 0; es = a.seg; ew = nw; return; end
            if (d == DEPTH) begin kind = 3; es = cs; ew = cw; return; end
            cs = a.seg; cw = nw;
        end
    endtask

    task automatic run(input string req, input int s, input int w, input int idx, input bit poke);
        int kind, es, ew, waited;
        model(s, w, idx, kind, es, ew);
        got_done = 0; got_trap = 0;
        @(negedge clk);
        index_val = WRD_W'(idx); start_seg = SEG_W'(s); start_wrd = WRD_W'(w); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R8", "busy after start", busy, 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            start_seg = SEG_W'(999); start_wrd = WRD_W'(5); start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (!got_done && !got_trap && waited < 600) begin
            @(negedge clk);
            waited++;
        end
        if (!got_done && !got_trap) begin
            n_checks++; n_fail++;
            $display("FAIL %s watchdog: actual no end expected end", req);
        end else if (kind == 0) begin
            check(got_done && !got_trap, req, "completion", got_trap, 0);
            check(got_seg == es && got_wrd == ew, req, "result",
                  {got_seg, got_wrd}, {es, ew});
        end else begin
            check(got_trap && !got_done, req, "trap raised", got_done, 0);
            check(got_kind == kind, req, "trap kind", got_kind, kind);
            check(got_seg == es && got_wrd == ew, req, "trap argument",
                  {got_seg, got_wrd}, {es, ew});
        end
        check(exp_q.size() == 0, "R1", "reads outstanding", exp_q.size(), 0);
        repeat (3) @(negedge clk);
        check(!busy && !rd_req, "R8", "idle after run", {busy, rd_req}, 0);
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R9 reset state
        check(!busy && !rd_req && !done && !trap, "R9", "reset outputs",
              {busy, rd_req, done, trap}, 0);
        rst = 1'b0;

        // R2 plain pointer
        mem[key(5, 100)] = mkw(7, 200, 0); mem[key(5, 101)] = mkw(0, 0, 0);
        run("R2", 5, 100, 0, 0);
        // R3 displacement select
        mem[key(5, 110)] = mkw(7, 200, 0); mem[key(5, 111)] = mkw(0, 30, 1);
        run("R3", 5, 110, 0, 0);
        // R3 index_val select
        mem[key(5, 120)] = mkw(7, 200, 0); mem[key(5, 121)] = mkw(0, 0, 2);
        run("R3", 5, 120, 1000, 0);
        // R3 wrap of the word sum
        mem[key(5, 130)] = mkw(7, 'h3FFFF, 0); mem[key(5, 131)] = mkw(0, 2, 1);
        run("R3", 5, 130, 0, 0);
        // R1 pair straddling the top word number
        mem[key(6, 'h3FFFF)] = mkw(9, 50, 0); mem[key(6, 0)] = mkw(0, 0, 0);
        run("R1", 6, 'h3FFFF, 0, 0);
        // R4 three-pair chain
        mem[key(10, 0)]  = mkw(11, 10, 0); mem[key(10, 1)]  = mkw(0, 5, 5);
        mem[key(11, 15)] = mkw(12, 20, 0); mem[key(11, 16)] = mkw(0, 0, 6);
        mem[key(12, 23)] = mkw(13, 40, 0); mem[key(12, 24)] = mkw(0, 0, 0);
        run("R4", 10, 0, 3, 0);
        // R5 unlinked pointer
        mem[key(20, 0)] = mkw(33, 444, 3); mem[key(20, 1)] = mkw(0, 0, 0);
        run("R5", 20, 0, 0, 0);
        // R5 unlinked pointer reached through a chain
        mem[key(60, 0)] = mkw(61, 0, 0);   mem[key(60, 1)] = mkw(0, 0, 4);
        mem[key(61, 0)] = mkw(77, 88, 3);  mem[key(61, 1)] = mkw(0, 0, 0);
        run("R5", 60, 0, 0, 0);
        // R6 undefined first mode
        mem[key(21, 0)] = mkw(1, 1, 5); mem[key(21, 1)] = mkw(0, 0, 0);
        run("R6", 21, 0, 0, 0);
        // R6 index select 3
        mem[key(22, 0)] = mkw(1, 1, 0); mem[key(22, 1)] = mkw(0, 0, 3);
        run("R6", 22, 0, 0, 0);
        // R6 reserved bit in second mode
        mem[key(23, 0)] = mkw(1, 1, 0); mem[key(23, 1)] = mkw(0, 0, 8);
        run("R6", 23, 0, 0, 0);
        // R7 exactly DEPTH pairs completes
        for (int i = 0; i < DEPTH; i++) begin
            mem[key(40 + i, 0)] = mkw(41 + i, 0, 0);
            mem[key(40 + i, 1)] = mkw(0, 0, (i < DEPTH - 1) ? 4 : 0);
        end
        run("R7", 40, 0, 0, 0);
        // R7 self-referencing pair hits the depth limit
        mem[key(50, 7)] = mkw(50, 7, 0); mem[key(50, 8)] = mkw(0, 0, 4);
        run("R7", 50, 7, 0, 0);
        // R8 start while busy is discarded
        run("R8", 10, 0, 3, 1);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1500000;
        n_checks++; n_fail++;
        $display("FAIL global watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule